// File: doc/BRIEF.md
# UltraDMA Host Burst Controller

This block is the host end of one ATA channel running UltraDMA bursts in either direction. When the device raises its DMA request and the system side has the controller enabled, the block latches a word count and a direction. It asserts the active-low acknowledge and then negates STOP to open the burst. From there it moves 16-bit words until the count runs out or the system aborts. To close, it raises STOP and keeps the acknowledge asserted until the device withdraws its request.

In an input burst (device to host), every transition of the device strobe, rising or falling, delivers one word. The word is handed to the receive side as a one-cycle write pulse. The host pauses the device by raising its ready line whenever the receive side reports it is nearly full. In an output burst (host to device), the block takes words from a transmit source and sends one word per transition of its own strobe. It stops toggling while the source is empty or while the device holds its ready line in the pause level. All device-driven inputs pass through two-flop synchronizers before any logic uses them. The device data is expected to stay stable for a few clock cycles around each strobe transition.

Top module: `udma_host_ctrl`

## Requirements
- R1: After reset, and whenever no burst is open: dmack_n_o=1, stop_o=1, hrdy_n_o=1, hstrobe_o=1, dd_oe_o=0, rx_we_o=0 and tx_pop_o=0.
- R2: A burst opens only when dmarq_i is high and en_i is high. dmack_n_o goes low at least one cycle before stop_o goes low. stop_o is low only while dmack_n_o is low, so no word moves before STOP is negated.
- R3: In an input burst (direction bit dir_i=1), each rising or falling transition of dstrobe_i delivers the word on dd_i once. The word appears as a single-cycle rx_we_o pulse with the word on rx_data_o, and words keep the order they were sent in.
- R4: The cycle after rx_afull_i is seen high, hrdy_n_o is high (host pause). It returns low once rx_afull_i is low during an open input burst. The device strobe may stay idle for any length of time without closing the burst.
- R5: In an output burst (dir_i=0), hstrobe_o starts high, and each transition of hstrobe_o while stop_o is low presents the next source word on dd_o. tx_pop_o pulses once per word taken, the cycle after the word on tx_data_i was latched. No word is taken while tx_empty_i is high.
- R6: Once drdy_n_i has been high (device pause) for two consecutive cycles, hstrobe_o does not change while it stays high and STOP is negated.
- R7: The count on count_i, latched when the burst opens, sets exactly how many words move. A count of zero opens and closes a burst with no data. Strobe transitions beyond the count are ignored.
- R8: abort_i high during the data phase closes the burst: stop_o rises and no further word is captured or sent.
- R9: On closing, stop_o is raised and hstrobe_o is parked high. dmack_n_o stays low until dmarq_i falls, then returns high.
- R10: The direction is latched when the burst opens, and changing dir_i mid-burst has no effect. dd_oe_o is high only while an output burst has STOP negated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | System allows a new burst to open |
| dir_i | input | 1 | 1 = input burst (device to host), 0 = output burst; latched at burst open |
| count_i | input | CW | Words in the next burst; latched at burst open |
| abort_i | input | 1 | System request to end the current burst |
| dmarq_i | input | 1 | Device DMA request |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | Host STOP line |
| hrdy_n_o | output | 1 | Host ready for input bursts, high = pause |
| hstrobe_o | output | 1 | Host data strobe for output bursts |
| drdy_n_i | input | 1 | Device ready for output bursts, high = pause |
| dstrobe_i | input | 1 | Device data strobe for input bursts |
| dd_i | input | DW | Data bus from the device |
| dd_o | output | DW | Data bus to the device |
| dd_oe_o | output | 1 | Host drives the data bus |
| rx_we_o | output | 1 | Received word valid pulse |
| rx_data_o | output | DW | Received word |
| rx_afull_i | input | 1 | Receive side nearly full |
| tx_data_i | input | DW | Head word of the transmit source |
| tx_empty_i | input | 1 | Transmit source has no word |
| tx_pop_o | output | 1 | Transmit word taken |

## Verification
Input bursts are driven with back-to-back strobe transitions, with randomly spaced ones, with a long idle strobe, and with host-side back-pressure. Together these separate edge-counted capture from level capture, and they show that a pause never closes a burst. Output bursts run against a source that goes empty at random and a device that pauses at random. A held device pause is also tested for stray strobe transitions. Count zero, extra device edges past the count, aborts in both directions and a direction flip in mid-burst expose off-by-one and latching faults. Seeded random bursts of mixed direction and length then check order and content word for word.

// File: rtl/udma_pkg.sv
// Shared types for the UltraDMA host burst controller.
package udma_pkg;

    // Burst sequencer states, in the order a burst passes through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACK   = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_PAUSE = 3'd4,
        ST_TERM  = 3'd5
    } udma_state_e;

endpackage

// File: rtl/udma_sync.sv
// Multi-stage flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is individually tolerant of one cycle of skew; a data bus
// passed through it must be held stable by its source around each change.
module udma_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/udma_word_ctr.sv
// Down-counter of words left in the current burst.
// Assumes load and dec are never high in the same cycle; load wins if so.
module udma_word_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    input  logic          dec_i,
    output logic          zero_o
);

    logic [CW-1:0] left_q;

    // Load at burst open, count down one per moved word, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= val_i;
        end else if (dec_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero_o = (left_q == '0);

endmodule

// File: rtl/udma_rx_path.sv
// Input-burst capture: detects both edges of the synchronized device strobe
// and registers one word per edge while capture is enabled.
// Assumes the strobe and data arrive through matching synchronizer depth.
module udma_rx_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_s_i,
    input  logic [DW-1:0] data_s_i,
    input  logic          cap_en_i,
    output logic          cap_o,
    output logic          rx_we_o,
    output logic [DW-1:0] rx_data_o
);

    logic stb_prev_q;

    // Remember the strobe level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_prev_q <= 1'b0;
        end else begin
            stb_prev_q <= stb_s_i;
        end
    end

    assign cap_o = (stb_s_i ^ stb_prev_q) & cap_en_i;

    // Hand each captured word to the receive side as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_we_o   <= 1'b0;
            rx_data_o <= '0;
        end else begin
            rx_we_o <= cap_o;
            if (cap_o) begin
                rx_data_o <= data_s_i;
            end
        end
    end

endmodule

// File: rtl/udma_tx_path.sv
// Output-burst sender: takes a word from the source, then toggles the host
// strobe one cycle later so the word is settled before its edge.
// Assumes run_i already folds in pause, abort and remaining-count conditions.
module udma_tx_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          park_i,
    input  logic          tx_empty_i,
    input  logic [DW-1:0] tx_data_i,
    output logic          fire_o,
    output logic          hstrobe_o,
    output logic [DW-1:0] dd_o,
    output logic          tx_pop_o
);

    logic pend_q;
    logic load;

    assign load   = run_i && !pend_q && !tx_empty_i;
    assign fire_o = run_i && pend_q;

    // Alternate between latching a word and toggling the strobe for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            hstrobe_o <= 1'b1;
            dd_o      <= '0;
            tx_pop_o  <= 1'b0;
        end else begin
            tx_pop_o <= load;
            if (load) begin
                dd_o   <= tx_data_i;
                pend_q <= 1'b1;
            end
            if (fire_o) begin
                hstrobe_o <= ~hstrobe_o;
                pend_q    <= 1'b0;
            end
            if (park_i) begin
                hstrobe_o <= 1'b1;
                pend_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/udma_host_ctrl.sv
// Host-side UltraDMA burst controller for one channel.
// Sequences acknowledge, STOP negation, data, pause and termination; routes
// words between the device bus and a FIFO-style system interface.
// Assumes all device inputs are asynchronous and the device holds data
// stable for a few clock cycles around each strobe transition.
module udma_host_ctrl
    import udma_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          dir_i,
    input  logic [CW-1:0] count_i,
    input  logic          abort_i,
    input  logic          dmarq_i,
    output logic          dmack_n_o,
    output logic          stop_o,
    output logic          hrdy_n_o,
    output logic          hstrobe_o,
    input  logic          drdy_n_i,
    input  logic          dstrobe_i,
    input  logic [DW-1:0] dd_i,
    output logic [DW-1:0] dd_o,
    output logic          dd_oe_o,
    output logic          rx_we_o,
    output logic [DW-1:0] rx_data_o,
    input  logic          rx_afull_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          tx_empty_i,
    output logic          tx_pop_o
);

    localparam int CTRL_W = 3;

    udma_state_e state_q, state_n;
    logic        dir_in_q;
    logic [CTRL_W-1:0] ctrl_s;
    logic        s_dmarq, s_drdy_n, s_dstb;
    logic [DW-1:0] s_dd;
    logic        cnt_zero, cap, fire, tx_run, open_burst, xfer_ph, data_ph_n;

    udma_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dmarq_i, drdy_n_i, dstrobe_i}),
        .q_o   (ctrl_s)
    );

    udma_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync_data (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dd_i),
        .q_o   (s_dd)
    );

    assign {s_dmarq, s_drdy_n, s_dstb} = ctrl_s;

    assign open_burst = (state_q == ST_IDLE) && s_dmarq && en_i;
    assign xfer_ph    = (state_q == ST_DATA) || (state_q == ST_PAUSE);
    assign tx_run     = (state_q == ST_DATA) && !dir_in_q && !cnt_zero
                        && !s_drdy_n && !abort_i;

    udma_word_ctr #(.CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (open_burst),
        .val_i  (count_i),
        .dec_i  (dir_in_q ? cap : fire),
        .zero_o (cnt_zero)
    );

    udma_rx_path #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_s_i   (s_dstb),
        .data_s_i  (s_dd),
        .cap_en_i  (xfer_ph && dir_in_q && !cnt_zero),
        .cap_o     (cap),
        .rx_we_o   (rx_we_o),
        .rx_data_o (rx_data_o)
    );

    udma_tx_path #(.DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (tx_run),
        .park_i     (state_q == ST_TERM),
        .tx_empty_i (tx_empty_i),
        .tx_data_i  (tx_data_i),
        .fire_o     (fire),
        .hstrobe_o  (hstrobe_o),
        .dd_o       (dd_o),
        .tx_pop_o   (tx_pop_o)
    );

    // Choose the next burst state from the handshake lines and counters.
    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE:  if (open_burst) state_n = ST_ACK;
            ST_ACK:   state_n = ST_START;
            ST_START: state_n = (dir_in_q && rx_afull_i) ? ST_PAUSE : ST_DATA;
            ST_DATA: begin
                if (abort_i || cnt_zero)                        state_n = ST_TERM;
                else if (dir_in_q ? rx_afull_i : s_drdy_n)      state_n = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (abort_i || cnt_zero)                        state_n = ST_TERM;
                else if (dir_in_q ? !rx_afull_i : !s_drdy_n)    state_n = ST_DATA;
            end
            ST_TERM:  if (!s_dmarq) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    assign data_ph_n = (state_n == ST_START) || (state_n == ST_DATA)
                       || (state_n == ST_PAUSE);

    // Advance the state and latch direction when a burst opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dir_in_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (open_burst) begin
                dir_in_q <= dir_i;
            end
        end
    end

    // Register the channel handshake outputs from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmack_n_o <= 1'b1;
            stop_o    <= 1'b1;
            hrdy_n_o  <= 1'b1;
            dd_oe_o   <= 1'b0;
        end else begin
            dmack_n_o <= (state_n == ST_IDLE);
            stop_o    <= !data_ph_n;
            hrdy_n_o  <= !(dir_in_q && (state_n == ST_DATA));
            dd_oe_o   <= !dir_in_q && data_ph_n && (state_q != ST_IDLE);
        end
    end

endmodule

// File: rtl/udma_host_ctrl_chk.sv
// Protocol checker for the UltraDMA host burst controller, bound to the top.
// Observes ports only; keeps a small counter to judge a held device pause.
module udma_host_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_afull_i,
    input logic tx_empty_i,
    input logic drdy_n_i,
    input logic dmack_n_o,
    input logic stop_o,
    input logic hrdy_n_o,
    input logic hstrobe_o,
    input logic dd_oe_o,
    input logic rx_we_o,
    input logic tx_pop_o
);

    logic [1:0] pause_run_q;

    // Count consecutive cycles of device pause, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_run_q <= '0;
        end else if (drdy_n_i) begin
            pause_run_q <= (pause_run_q == 2'd3) ? 2'd3 : pause_run_q + 2'd1;
        end else begin
            pause_run_q <= '0;
        end
    end

    assert_stop_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_o |-> !dmack_n_o);

    assert_ack_leads_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_o) |-> $past(!dmack_n_o));

    assert_rx_only_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we_o |-> !dmack_n_o);

    assert_host_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_afull_i |=> hrdy_n_o);

    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> $past(!tx_empty_i));

    assert_strobe_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_run_q >= 2'd2 && drdy_n_i && !stop_o) |=> $stable(hstrobe_o));

    assert_ack_drop_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> (stop_o && $past(stop_o)));

    assert_strobe_parked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dmack_n_o |-> hstrobe_o);

    assert_oe_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe_o |-> (!dmack_n_o && !stop_o));

endmodule

bind udma_host_ctrl udma_host_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_afull_i (rx_afull_i),
    .tx_empty_i (tx_empty_i),
    .drdy_n_i   (drdy_n_i),
    .dmack_n_o  (dmack_n_o),
    .stop_o     (stop_o),
    .hrdy_n_o   (hrdy_n_o),
    .hstrobe_o  (hstrobe_o),
    .dd_oe_o    (dd_oe_o),
    .rx_we_o    (rx_we_o),
    .tx_pop_o   (tx_pop_o)
);

// File: tb/tb_udma_host_ctrl.sv
module tb_udma_host_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, dir_i = 1'b0, abort_i = 1'b0, dmarq_i = 1'b0;
    logic [15:0] count_i = '0;
    logic        drdy_n_i = 1'b0, dstrobe_i = 1'b1, rx_afull_i = 1'b0;
    logic [15:0] dd_i = '0;
    logic [15:0] tx_data_i;
    logic        tx_empty_i;
    logic        dmack_n_o, stop_o, hrdy_n_o, hstrobe_o, dd_oe_o, rx_we_o, tx_pop_o;
    logic [15:0] dd_o, rx_data_o;

    always #10 clk = ~clk;  // 50 MHz

    udma_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .count_i(count_i),
        .abort_i(abort_i), .dmarq_i(dmarq_i), .dmack_n_o(dmack_n_o), .stop_o(stop_o),
        .hrdy_n_o(hrdy_n_o), .hstrobe_o(hstrobe_o), .drdy_n_i(drdy_n_i),
        .dstrobe_i(dstrobe_i), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o),
        .rx_we_o(rx_we_o), .rx_data_o(rx_data_o), .rx_afull_i(rx_afull_i),
        .tx_data_i(tx_data_i), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o)
    );

    int total = 0, bad = 0, order_bad = 0;
    bit fin = 1'b0;
    logic [15:0] rx_q [64];
    logic [15:0] out_q [64];
    logic [15:0] tx_mem [64];
    int rx_n = 0, out_n = 0, pop_n = 0, tx_rd = 0, tx_lim = 0;
    bit tx_hold = 1'b0;
    logic prev_hs = 1'b1;

    assign tx_data_i  = tx_mem[tx_rd[5:0]];
    assign tx_empty_i = tx_hold || (tx_rd >= tx_lim);

    function automatic logic [15:0] wv(int base, int i);
        return 16'((base * 32'h2F1) ^ (i * 32'h1357) ^ 32'hA5C3);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!stop_o && dmack_n_o) order_bad++;
            if (rx_we_o && rx_n < 64) begin rx_q[rx_n] = rx_data_o; rx_n++; end
            if (rx_we_o && rx_n >= 64) rx_n++;
            if (hstrobe_o != prev_hs && !stop_o) begin
                if (out_n < 64) out_q[out_n] = dd_o;
                out_n++;
            end
            if (tx_pop_o) begin pop_n++; tx_rd++; end
        end
        prev_hs = hstrobe_o;
    end

    task automatic open_burst(bit dir, int cnt);
        dir_i = dir; count_i = 16'(cnt); dmarq_i = 1'b1;
        while (stop_o) @(negedge clk);
        chk(order_bad == 0, "R2 ack before stop negation", order_bad, 0);
    endtask

    task automatic close_burst();
        while (!stop_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(dmack_n_o == 1'b0, "R9 ack held until request drops", dmack_n_o, 0);
        chk(hstrobe_o == 1'b1, "R9 strobe parked high", hstrobe_o, 1);
        dmarq_i = 1'b0;
        for (int w = 0; w < 10 && !dmack_n_o; w++) @(negedge clk);
        chk(dmack_n_o == 1'b1, "R9 ack released", dmack_n_o, 1);
        repeat (2) @(negedge clk);
    endtask

    // Device side of an input burst: one strobe transition per word.
    task automatic dev_in(int base, int n, int gapmax, bit rnd_full);
        for (int i = 0; i < n; i++) begin
            if (rnd_full && ($urandom % 4 == 0)) begin
                rx_afull_i = 1'b1;
                repeat (6) @(negedge clk);
                rx_afull_i = 1'b0;
            end
            while (!stop_o && hrdy_n_o) @(negedge clk);
            if (stop_o) break;
            dd_i = wv(base, i);
            @(negedge clk);
            dstrobe_i = ~dstrobe_i;
            repeat (4 + ((gapmax > 0) ? ($urandom % gapmax) : 0)) @(negedge clk);
        end
    endtask

    task automatic cmp_rx(int base, int n, string tag);
        chk(rx_n == n, {tag, " word count"}, rx_n, n);
        for (int i = 0; i < n && i < rx_n && i < 64; i++)
            chk(rx_q[i] == wv(base, i), {tag, " word value"}, rx_q[i], wv(base, i));
    endtask

    task automatic cmp_out(int base, int n, string tag);
        chk(out_n == n, {tag, " word count"}, out_n, n);
        for (int i = 0; i < n && i < out_n && i < 64; i++)
            chk(out_q[i] == wv(base, i), {tag, " word value"}, out_q[i], wv(base, i));
    endtask

    task automatic run_in(int base, int cnt, int send, int gapmax, bit rnd_full);
        rx_n = 0;
        open_burst(1'b1, cnt);
        dev_in(base, send, gapmax, rnd_full);
        close_burst();
        cmp_rx(base, (send < cnt) ? send : cnt, "R3 R7 input");
    endtask

    task automatic run_out(int base, int cnt, bit rnd, bit flip);
        for (int i = 0; i < cnt; i++) tx_mem[i] = wv(base, i);
        tx_rd = 0; tx_lim = cnt; out_n = 0; pop_n = 0; rx_n = 0;
        open_burst(1'b0, cnt);
        if (flip) begin
            dir_i = 1'b1;
            @(negedge clk);
            chk(dd_oe_o == 1'b1 || stop_o, "R10 bus driven in output burst", dd_oe_o, 1);
        end
        while (!stop_o) begin
            @(negedge clk);
            if (rnd) begin
                drdy_n_i = ($urandom % 5 == 0);
                tx_hold  = ($urandom % 4 == 0);
            end
        end
        drdy_n_i = 1'b0; tx_hold = 1'b0;
        close_burst();
        cmp_out(base, cnt, "R5 R7 output");
        chk(pop_n == cnt, "R5 one pop per word", pop_n, cnt);
        if (flip) chk(rx_n == 0, "R10 direction held", rx_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int saved;
        void'($urandom(32'd7411));
        repeat (5) @(negedge clk);
        chk(dmack_n_o == 1, "R1 reset ack", dmack_n_o, 1);
        chk(stop_o == 1, "R1 reset stop", stop_o, 1);
        chk(hrdy_n_o == 1, "R1 reset host ready", hrdy_n_o, 1);
        chk(hstrobe_o == 1, "R1 reset strobe", hstrobe_o, 1);
        chk(dd_oe_o == 0, "R1 reset bus enable", dd_oe_o, 0);
        chk(rx_we_o == 0 && tx_pop_o == 0, "R1 reset pulses", rx_we_o, 0);
        rst_n = 1'b1;

        // R2: request without enable opens nothing.
        dmarq_i = 1'b1;
        repeat (8) @(negedge clk);
        chk(dmack_n_o == 1 && stop_o == 1, "R2 no open while disabled", dmack_n_o, 1);
        dmarq_i = 1'b0; en_i = 1'b1;
        repeat (4) @(negedge clk);

        // R3 back-to-back input words.
        run_in(1, 4, 4, 0, 1'b0);

        // R4 host pause and long idle device strobe.
        rx_n = 0;
        open_burst(1'b1, 4);
        dev_in(2, 1, 0, 1'b0);
        rx_afull_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(hrdy_n_o == 1, "R4 host pause raised", hrdy_n_o, 1);
        repeat (60) @(negedge clk);
        chk(stop_o == 0 && dmack_n_o == 0, "R4 burst survives idle strobe", stop_o, 0);
        rx_afull_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(hrdy_n_o == 0, "R4 host pause released", hrdy_n_o, 0);
        for (int i = 1; i < 4; i++) begin
            dd_i = wv(2, i); @(negedge clk); dstrobe_i = ~dstrobe_i;
            repeat (4) @(negedge clk);
        end
        close_burst();
        cmp_rx(2, 4, "R4 input after pause");

        // R7 extra device edges past the count.
        rx_n = 0;
        open_burst(1'b1, 3);
        for (int i = 0; i < 6; i++) begin
            dd_i = wv(3, i); @(negedge clk); dstrobe_i = ~dstrobe_i;
            repeat (4) @(negedge clk);
        end
        close_burst();
        cmp_rx(3, 3, "R7 extra edges ignored");

        // R7 zero count.
        run_in(4, 0, 3, 0, 1'b0);
        run_out(5, 0, 1'b0, 1'b0);

        // R5 output basic.
        run_out(6, 6, 1'b0, 1'b0);

        // R6 device pause holds the strobe.
        for (int i = 0; i < 8; i++) tx_mem[i] = wv(7, i);
        tx_rd = 0; tx_lim = 8; out_n = 0; pop_n = 0;
        open_burst(1'b0, 8);
        while (out_n < 2) @(negedge clk);
        drdy_n_i = 1'b1;
        repeat (3) @(negedge clk);
        saved = out_n;
        repeat (20) @(negedge clk);
        chk(out_n == saved, "R6 no strobe toggles in device pause", out_n, saved);
        chk(stop_o == 0, "R6 pause keeps burst open", stop_o, 0);
        drdy_n_i = 1'b0;
        close_burst();
        cmp_out(7, 8, "R6 output after pause");

        // R5 empty source stalls, no toggles.
        for (int i = 0; i < 4; i++) tx_mem[i] = wv(8, i);
        tx_rd = 0; tx_lim = 2; out_n = 0; pop_n = 0;
        open_burst(1'b0, 4);
        repeat (30) @(negedge clk);
        chk(out_n == 2 && pop_n == 2, "R5 stall on empty source", out_n, 2);
        tx_lim = 4;
        close_burst();
        cmp_out(8, 4, "R5 output after refill");

        // R8 abort during input.
        rx_n = 0;
        open_burst(1'b1, 10);
        dev_in(9, 3, 0, 1'b0);
        abort_i = 1'b1;
        while (!stop_o) @(negedge clk);
        for (int i = 3; i < 5; i++) begin
            dd_i = wv(9, i); @(negedge clk); dstrobe_i = ~dstrobe_i;
            repeat (4) @(negedge clk);
        end
        abort_i = 1'b0;
        close_burst();
        cmp_rx(9, 3, "R8 input abort");

        // R8 abort during output.
        for (int i = 0; i < 20; i++) tx_mem[i] = wv(10, i);
        tx_rd = 0; tx_lim = 20; out_n = 0; pop_n = 0;
        open_burst(1'b0, 20);
        while (out_n < 3) @(negedge clk);
        abort_i = 1'b1;
        saved = out_n;
        while (!stop_o) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(out_n == saved, "R8 output abort stops strobes", out_n, saved);
        abort_i = 1'b0;
        close_burst();

        // R10 direction flip mid-burst.
        run_out(11, 5, 1'b0, 1'b1);

        // Seeded random bursts.
        for (int b = 0; b < 14; b++) begin
            int cnt;
            cnt = 1 + int'($urandom % 12);
            if ($urandom % 2 == 0) run_in(20 + b, cnt, cnt + 1, 6, 1'b1);
            else                   run_out(20 + b, cnt, 1'b1, 1'b0);
        end

        chk(order_bad == 0, "R2 stop never negated without ack", order_bad, 0);
        if (!fin) begin
            fin = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule